// File: doc/BRIEF.md
# Micro-Operation Sequencer with Split Decode

This block steps through a program of micro-operation words held in an external instruction memory and hands each operation to a worker unit. A host starts a program by pulsing a start input together with the program's entry address. The sequencer then repeats one loop for every word:

- It fetches the word, spending one cycle on the fetch.
- It decodes the word over two registered cycles.
- It hands the operation to the worker with a single-cycle start pulse.
- It waits for the worker to signal completion, then moves to the next address.

A dedicated stop word ends the program and raises a one-cycle done pulse toward the host.

Decoding is split deliberately into two registered cycles. This keeps the path from the memory's read data to the worker's control registers short. The price is two extra cycles of latency on every executed word. The controller is a five-state machine stored in a three-bit register. Its next-state logic sends any of the three unused codes back to idle.

The instruction memory must be synchronous, with its read data valid in the cycle after the address is presented with the enable high. Reset is active low and asynchronous. Its release must already be synchronous to the clock.

Top module: `uop_engine`

## Requirements
- R1: While reset is low, and in the first cycle after it, the outputs host_done, imem_en and worker_start are low.
- R2: A host_start pulse while idle loads host_start_pc. The next cycle is a fetch cycle: imem_en is high for exactly that one cycle, with imem_addr equal to the address being fetched.
- R3: An instruction word of 10 bits (defaults) holds an opcode in bits [9:6], a source bank in bits [5:3] and a destination bank in bits [2:0]. Opcode 0 is STOP. Opcodes 1 to 4 are worker operations. Opcodes 5 to 15 are unassigned.
- R4: For opcode k in 1..4, worker_flags is one-hot with bit k-1 set. worker_src and worker_dst carry the word's bank fields. All three are valid when worker_start is high and stay unchanged until worker_done is accepted.
- R5: worker_start is a one-cycle pulse. It is high in the fourth cycle counting the fetch cycle as the first, meaning three clocks after that fetch cycle.
- R6: After worker_start, the sequencer waits any number of cycles for worker_done. The cycle after worker_done is accepted is a fetch of the next address, and the address wraps from the top of the address space to 0.
- R7: A STOP word produces no worker_start. It produces a single-cycle host_done three clocks after its fetch cycle, and the sequencer then returns to idle.
- R8: An unassigned opcode produces neither worker_start nor host_done. The next address is fetched three clocks after the skipped word's fetch cycle.
- R9: host_start is ignored while a program is running. The running program's sequence of fetches and worker operations is not altered.
- R10: worker_done is ignored when no operation is outstanding. Pulsing it while idle produces no fetch, no worker_start and no host_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| host_start | input | 1 | Start pulse from the host, taken only when idle |
| host_start_pc | input | AW (4) | Program entry address, sampled with host_start |
| host_done | output | 1 | One-cycle pulse when a STOP word is reached |
| imem_en | output | 1 | Instruction memory read enable, high in fetch cycles |
| imem_addr | output | AW (4) | Instruction memory read address |
| imem_rdata | input | OPC_W+2*BANK_W (10) | Instruction memory read data, valid one cycle after the fetch |
| worker_start | output | 1 | One-cycle pulse issuing an operation to the worker |
| worker_flags | output | NFLAG (4) | One-hot operation flags for the worker |
| worker_src | output | BANK_W (3) | Source bank selector |
| worker_dst | output | BANK_W (3) | Destination bank selector |
| worker_done | input | 1 | Worker completion, taken while an operation is outstanding |

## Verification
The assertions check the following on every cycle:
- worker_start and host_done each appear exactly three clocks after a fetch.
- Both are single-cycle pulses and are never high together.
- Every fetch lasts one cycle.
- The issued flags are one-hot.
- The flags hold steady while the worker is busy.
- The controller never holds one of its three unused codes.

Only the bench's scenarios can show the rest:
- That the address sequence follows the program, including wrap-around and skipped words.
- That the bank fields reach the worker unaltered.
- That stray host_start and worker_done pulses leave a run untouched.

// File: rtl/uop_pkg.sv
package uop_pkg;
  localparam int OPC_W = 4;
  localparam int NFLAG = 4;
  localparam logic [OPC_W-1:0] OPC_STOP = '0;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_DEC1  = 3'd2,
    ST_DEC2  = 3'd3,
    ST_EXEC  = 3'd4
  } state_t;

  typedef struct packed {
    logic load_pc;
    logic inc_pc;
    logic fetch;
    logic dec1;
    logic dec2;
  } ctrl_t;
endpackage

// File: rtl/uop_pc.sv
module uop_pc #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] pc
);
  logic [AW-1:0] pc_q, pc_d;
  logic          pc_en;

  always_comb begin
    pc_en = load | inc;
    pc_d  = load ? load_val : pc_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  assign pc = pc_q;
endmodule

// File: rtl/uop_decode.sv
module uop_decode import uop_pkg::*; #(
  parameter int BANK_W = 3,
  localparam int IW = OPC_W + 2*BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stage1_en,
  input  logic              stage2_en,
  input  logic [IW-1:0]     word,
  output logic              cls_stop,
  output logic              cls_op,
  output logic [NFLAG-1:0]  flags,
  output logic [BANK_W-1:0] src,
  output logic [BANK_W-1:0] dst
);
  // stage 1: split fields and classify the opcode
  logic [OPC_W-1:0]  op_q;
  logic [BANK_W-1:0] src1_q, dst1_q;
  logic              stop_q, op_ok_q;
  logic              stop_d, op_ok_d;
  logic [OPC_W-1:0]  op_d;

  always_comb begin
    op_d    = word[IW-1 -: OPC_W];
    stop_d  = (op_d == OPC_STOP);
    op_ok_d = (op_d != OPC_STOP) && (int'(op_d) <= NFLAG);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= '0;
      src1_q  <= '0;
      dst1_q  <= '0;
      stop_q  <= 1'b0;
      op_ok_q <= 1'b0;
    end else if (stage1_en) begin
      op_q    <= op_d;
      src1_q  <= word[2*BANK_W-1 -: BANK_W];
      dst1_q  <= word[BANK_W-1:0];
      stop_q  <= stop_d;
      op_ok_q <= op_ok_d;
    end
  end

  // stage 2: expand the opcode into one-hot worker flags
  logic [NFLAG-1:0] flags_d;

  for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
    assign flags_d[gi] = (op_q == OPC_W'(gi + 1));
  end

  logic [NFLAG-1:0]  flags_q;
  logic [BANK_W-1:0] src2_q, dst2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      src2_q  <= '0;
      dst2_q  <= '0;
    end else if (stage2_en) begin
      flags_q <= flags_d;
      src2_q  <= src1_q;
      dst2_q  <= dst1_q;
    end
  end

  assign cls_stop = stop_q;
  assign cls_op   = op_ok_q;
  assign flags    = flags_q;
  assign src      = src2_q;
  assign dst      = dst2_q;
endmodule

// File: rtl/uop_ctrl.sv
module uop_ctrl import uop_pkg::*; (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   host_start,
  input  logic   worker_done,
  input  logic   cls_stop,
  input  logic   cls_op,
  output state_t state,
  output ctrl_t  ctl,
  output logic   worker_start,
  output logic   host_done
);
  state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    ctl  = '0;
    case (st_q)
      ST_IDLE: begin
        if (host_start) begin
          st_d        = ST_FETCH;
          ctl.load_pc = 1'b1;
        end
      end
      ST_FETCH: begin
        ctl.fetch = 1'b1;
        st_d      = ST_DEC1;
      end
      ST_DEC1: begin
        ctl.dec1 = 1'b1;
        st_d     = ST_DEC2;
      end
      ST_DEC2: begin
        ctl.dec2 = 1'b1;
        if (cls_stop) begin
          st_d = ST_IDLE;
        end else if (cls_op) begin
          st_d = ST_EXEC;
        end else begin
          st_d       = ST_FETCH;
          ctl.inc_pc = 1'b1;
        end
      end
      ST_EXEC: begin
        if (worker_done) begin
          st_d       = ST_FETCH;
          ctl.inc_pc = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  logic start_d, hdone_d;

  always_comb begin
    start_d = ctl.dec2 & cls_op & ~cls_stop;
    hdone_d = ctl.dec2 & cls_stop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      worker_start <= 1'b0;
      host_done    <= 1'b0;
    end else begin
      st_q         <= st_d;
      worker_start <= start_d;
      host_done    <= hdone_d;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/uop_engine.sv
module uop_engine import uop_pkg::*; #(
  parameter int AW     = 4,
  parameter int BANK_W = 3,
  localparam int IW    = OPC_W + 2*BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_start,
  input  logic [AW-1:0]     host_start_pc,
  output logic              host_done,
  output logic              imem_en,
  output logic [AW-1:0]     imem_addr,
  input  logic [IW-1:0]     imem_rdata,
  output logic              worker_start,
  output logic [NFLAG-1:0]  worker_flags,
  output logic [BANK_W-1:0] worker_src,
  output logic [BANK_W-1:0] worker_dst,
  input  logic              worker_done
);
  state_t        state;
  ctrl_t         ctl;
  logic          cls_stop, cls_op;
  logic [AW-1:0] pc;

  uop_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_start   (host_start),
    .worker_done  (worker_done),
    .cls_stop     (cls_stop),
    .cls_op       (cls_op),
    .state        (state),
    .ctl          (ctl),
    .worker_start (worker_start),
    .host_done    (host_done)
  );

  uop_pc #(.AW(AW)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ctl.load_pc),
    .load_val (host_start_pc),
    .inc      (ctl.inc_pc),
    .pc       (pc)
  );

  uop_decode #(.BANK_W(BANK_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .stage1_en (ctl.dec1),
    .stage2_en (ctl.dec2),
    .word      (imem_rdata),
    .cls_stop  (cls_stop),
    .cls_op    (cls_op),
    .flags     (worker_flags),
    .src       (worker_src),
    .dst       (worker_dst)
  );

  assign imem_en   = ctl.fetch;
  assign imem_addr = pc;
endmodule

// File: rtl/uop_engine_chk.sv
module uop_engine_chk import uop_pkg::*; (
  input logic             clk,
  input logic             rst_n,
  input logic             host_done,
  input logic             imem_en,
  input logic             worker_start,
  input logic             worker_done,
  input logic [NFLAG-1:0] worker_flags,
  input logic [2:0]       state
);
  AST_START_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    worker_start |-> $past(imem_en, 3)); // R5
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    worker_start |=> !worker_start); // R5
  AST_HDONE_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |-> $past(imem_en, 3)); // R7
  AST_HDONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done); // R7
  AST_NO_START_WITH_HDONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(worker_start && host_done)); // R7
  AST_FETCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    imem_en |=> !imem_en); // R2
  AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    worker_start |-> ($countones(worker_flags) == 1)); // R4
  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd4 && !worker_done) |=> $stable(worker_flags)); // R4
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    state <= 3'd4); // R6
endmodule

bind uop_engine uop_engine_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_done    (host_done),
  .imem_en      (imem_en),
  .worker_start (worker_start),
  .worker_done  (worker_done),
  .worker_flags (worker_flags),
  .state        (state)
);

// File: tb/sim_uop_engine.sv
`timescale 1ns/1ps
module sim_uop_engine;
  localparam int AW = 4;
  localparam int BW = 3;
  localparam int IW = 4 + 2*BW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_start = 1'b0;
  logic [AW-1:0] host_start_pc = '0;
  logic host_done, imem_en, worker_start;
  logic [AW-1:0] imem_addr;
  logic [IW-1:0] imem_rdata;
  logic [3:0] worker_flags;
  logic [BW-1:0] worker_src, worker_dst;
  logic worker_done = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  always #4 clk = ~clk;

  uop_engine u0 (
    .clk(clk), .rst_n(rst_n), .host_start(host_start), .host_start_pc(host_start_pc),
    .host_done(host_done), .imem_en(imem_en), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .worker_start(worker_start), .worker_flags(worker_flags), .worker_src(worker_src),
    .worker_dst(worker_dst), .worker_done(worker_done)
  );

  logic [IW-1:0] mem [DEPTH];

  always_ff @(posedge clk) if (imem_en) imem_rdata <= mem[imem_addr];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] mk(input int op, input int s, input int d);
    return {op[3:0], s[BW-1:0], d[BW-1:0]};
  endfunction

  function automatic int exp_flags(input int op);
    return 1 << (op - 1);
  endfunction

  // mode 0: mixed valid/unassigned words, mode 1: unassigned only
  task automatic gen(input int spc, input int len, input int mode);
    for (int i = 0; i < DEPTH; i++) mem[i] = mk(5 + ($urandom % 11), $urandom, $urandom);
    for (int i = 0; i < len; i++) begin
      int op;
      if (mode == 1) op = 5 + ($urandom % 11);
      else op = (($urandom % 10) < 7) ? 1 + ($urandom % 4) : 5 + ($urandom % 11);
      mem[(spc + i) % DEPTH] = mk(op, $urandom, $urandom);
    end
    mem[(spc + len) % DEPTH] = mk(0, $urandom, $urandom);
  endtask

  task automatic run(input int spc, input bit poke);
    int visit[DEPTH];
    int eop[DEPTH], esrc[DEPTH], edst[DEPTH], eskip[DEPTH];
    int nv = 0, ne = 0, skips = 0, fskip = 0;
    int now = 0, refc = 0, k = 0, f = 0, pend = -1;
    bit fin = 0, prev_start = 0;
    for (int i = 0; i < DEPTH; i++) begin
      int a = (spc + i) % DEPTH;
      int op = int'(mem[a][IW-1 -: 4]);
      visit[nv] = a; nv++;
      if (op == 0) begin fskip = skips; break; end
      if (op <= 4) begin
        eop[ne] = op; esrc[ne] = int'(mem[a][2*BW-1 -: BW]); edst[ne] = int'(mem[a][BW-1:0]);
        eskip[ne] = skips; skips = 0; ne++;
      end else skips++;
    end
    @(negedge clk);
    host_start = 1'b1; host_start_pc = AW'(spc);
    while (!fin && now < 3000) begin
      @(negedge clk);
      now++;
      host_start = 1'b0; worker_done = 1'b0;
      if (poke && now == 6) begin host_start = 1'b1; host_start_pc = AW'(spc + 3); end // R9 stray start
      if (imem_en) begin
        chk(f < nv && int'(imem_addr) == visit[f], "R2/R6/R8/R9 fetch address", int'(imem_addr), (f < nv) ? visit[f] : -1);
        f++;
      end
      chk(!(worker_start && prev_start), "R5 start pulse width", 1, 0);
      if (worker_start) begin
        if (k < ne) begin
          chk(now == refc + 4 + 3*eskip[k], "R5/R8 start timing", now, refc + 4 + 3*eskip[k]);
          chk(int'(worker_flags) == exp_flags(eop[k]), "R3/R4 flags", int'(worker_flags), exp_flags(eop[k]));
          chk(int'(worker_src) == esrc[k] && int'(worker_dst) == edst[k], "R3/R4 banks",
              int'({worker_src, worker_dst}), (esrc[k] << BW) | edst[k]);
        end else chk(0, "R7/R8 unexpected start", 1, 0);
        k++;
        pend = int'($urandom % 4);
      end
      prev_start = worker_start;
      if (pend == 0) begin
        chk(int'(worker_flags) == exp_flags(eop[k-1]), "R4 flags held", int'(worker_flags), exp_flags(eop[k-1]));
        worker_done = 1'b1; refc = now; pend = -1;
      end else if (pend > 0) pend--;
      if (host_done) begin
        chk(k == ne, "R7 ops before stop", k, ne);
        chk(now == refc + 4 + 3*fskip, "R7 host_done timing", now, refc + 4 + 3*fskip);
        chk(f == nv, "R6 fetch count", f, nv);
        fin = 1;
      end
    end
    chk(fin, "R7 program finished", int'(fin), 1);
    @(negedge clk);
    chk(!host_done && !worker_start && !imem_en, "R7 done pulse one cycle", int'(host_done), 0);
  endtask

  initial begin
    void'($urandom(32'd5150));
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!host_done && !imem_en && !worker_start, "R1 outputs in reset", int'({host_done, imem_en, worker_start}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!host_done && !imem_en && !worker_start, "R1 outputs after reset", int'({host_done, imem_en, worker_start}), 0);
    // R10: stray worker_done while idle
    for (int i = 0; i < 3; i++) begin
      worker_done = 1'b1;
      @(negedge clk);
      chk(!imem_en && !worker_start && !host_done, "R10 stray done while idle", int'({imem_en, worker_start, host_done}), 0);
    end
    worker_done = 1'b0;
    @(negedge clk);
    chk(!imem_en && !worker_start && !host_done, "R10 idle after stray done", int'({imem_en, worker_start, host_done}), 0);
    // directed: lone STOP (R7), wrap (R6), all unassigned (R8), stray start (R9)
    gen(5, 0, 0);  run(5, 0);
    gen(14, 5, 0); run(14, 0);
    gen(2, 4, 1);  run(2, 0);
    gen(7, 6, 0);  mem[7] = mk(1, 2, 5); run(7, 1);
    for (int t = 0; t < 40; t++) begin
      int spc = int'($urandom % DEPTH);
      gen(spc, 1 + int'($urandom % 12), 0);
      run(spc, 0);
    end
    ended = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule